// File: doc/BRIEF.md
# Local-Bus Chip-Select Decoder

This block watches host bus cycles and turns each one into active-low chip selects for peripherals on a local bus. An I/O cycle is compared against a base address for an I/O window. The window size is programmable. A memory cycle is compared against a base address for a 4 KB window that is always split into four 1 KB regions. Within the I/O window, one programmable address bit sets the lowest decode bit. Depending on where that bit lies relative to the window's top address bit, the window splits into four regions, two regions, or stays whole on the first select.

A small configuration register holds four fields: the I/O window size, the split bit, a soft-reset bit and a local clock enable. The register loads on a write strobe. The block merges the host reset with the soft-reset bit and drives the result onto a complementary pair of local reset outputs. It also drives a gated copy of the host clock. The chip selects are combinational from the cycle inputs and the registered configuration.

Top module: `lbus_cs_decoder`

## Requirements
- R1: After host reset the configuration is: I/O size code 3 (32 bytes), split code 1, soft reset 0, clock enable 0. A 32-byte window therefore splits into four regions on address bits 4:3.
- R2: An I/O size code n from 0 to 6 gives a window of 4<<n bytes. Code 7 gives 256 bytes. The I/O base compare uses only the address bits at and above log2 of the window size.
- R3: The decode bit index d is the split code plus 2. If d+2 is at most log2(window size), the I/O select index is address bits d+1:d, giving four regions (io_cs_no bit k low for index k).
- R4: If d is the top active address bit of the I/O window (d+1 equals log2 of the window size), address bit d selects io_cs_no[1] when 1 and io_cs_no[0] when 0.
- R5: If d lies above the window's active address bits, every matching I/O cycle drives only io_cs_no[0].
- R6: A memory cycle whose address bits 31:12 equal those of the memory base drives mem_cs_no[k] low, with k taken from address bits 11:10.
- R7: All selects stay high when no cycle is valid or the base does not match. I/O selects respond only to I/O cycles (cyc_is_mem_i=0) and memory selects only to memory cycles, so the two groups are never active together.
- R8: lrst_o is high, and lrst_no is its complement, while rst_ni is low or the soft-reset bit is 1.
- R9: The soft-reset bit stays 1 until a configuration write clears it. A host reset returns every field to its default.
- R10: On a rising clock edge with cfg_we_i high, cfg_wdata_i is loaded: bits 2:0 are the I/O size code, bits 6:3 the split code, bit 7 soft reset and bit 8 clock enable. The new value acts after that edge.
- R11: While clock enable is 1, lclk_o follows clk_i. Otherwise lclk_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host bus clock |
| rst_ni | input | 1 | Host bus reset, active low, asynchronous |
| cyc_valid_i | input | 1 | Bus cycle valid |
| cyc_is_mem_i | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| addr_i | input | 32 | Cycle address |
| io_base_i | input | 32 | I/O window base address |
| mem_base_i | input | 32 | Memory window base address |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 9 | Configuration write data |
| io_cs_no | output | 4 | I/O chip selects, active low |
| mem_cs_no | output | 4 | Memory chip selects, active low |
| lrst_o | output | 1 | Local reset, active high |
| lrst_no | output | 1 | Local reset, active low |
| lclk_o | output | 1 | Gated copy of the host clock |

## Verification
Directed cases place the split bit at each of the three positions relative to the top window bit: second-highest, highest, and above the window. This shows that the four-way, two-way and single-select paths are chosen by the comparison with the window size, not by the split code alone. The window is also taken to its extremes of 4 and 256 bytes, where the top bit and the base-compare boundary move. Random cycles then mix I/O and memory spaces, matching and non-matching bases, idle cycles, and occasional configuration rewrites. This separates an error in the base mask from an error in region selection, because addresses that differ only above the window must deselect while those that differ inside it must move between selects. The soft-reset and clock-enable sequences check that bits persist across unrelated cycles and that a host reset clears them.

// File: rtl/lbcs_pkg.sv
package lbcs_pkg;
  localparam int SIZE_W  = 3;
  localparam int SPLIT_W = 4;
  localparam int CFG_W   = SIZE_W + SPLIT_W + 2;

  typedef struct packed {
    logic               clk_en;
    logic               soft_rst;
    logic [SPLIT_W-1:0] split_sel;
    logic [SIZE_W-1:0]  io_size;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{clk_en: 1'b0, soft_rst: 1'b0,
                                 split_sel: 4'd1, io_size: 3'd3};
endpackage

// File: rtl/lbcs_cfg_reg.sv
module lbcs_cfg_reg
  import lbcs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RESET;
    else if (we_i) cfg_q <= cfg_t'(wdata_i);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/lbcs_io_dec.sv
module lbcs_io_dec
  import lbcs_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int NUM_CS        = 4,
  parameter int MIN_WIN_LOG2  = 2,
  parameter int MAX_SIZE_CODE = 6,
  parameter int SPLIT_BASE    = 2
) (
  input  logic               valid_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [SIZE_W-1:0]  size_code_i,
  input  logic [SPLIT_W-1:0] split_sel_i,
  output logic [NUM_CS-1:0]  cs_no
);
  localparam int CS_IDX_W = $clog2(NUM_CS);
  localparam int SH_W     = $clog2(ADDR_W) + 2;

  logic [SIZE_W-1:0]   size_eff;
  logic [SH_W-1:0]     win_log2;
  logic [SH_W-1:0]     dec_bit;
  logic [ADDR_W-1:0]   upper_mask;
  logic [ADDR_W-1:0]   shifted;
  logic                hit;
  logic [CS_IDX_W-1:0] region;

  always_comb begin
    size_eff = (size_code_i > SIZE_W'(MAX_SIZE_CODE)) ? SIZE_W'(MAX_SIZE_CODE) : size_code_i;
    win_log2 = SH_W'(size_eff) + SH_W'(MIN_WIN_LOG2);
    dec_bit  = SH_W'(split_sel_i) + SH_W'(SPLIT_BASE);
  end

  assign upper_mask = {ADDR_W{1'b1}} << win_log2;
  assign hit        = valid_i && (((addr_i ^ base_i) & upper_mask) == '0);
  assign shifted    = addr_i >> dec_bit;

  // split bit position relative to window top picks 4, 2 or 1 region
  always_comb begin
    if (dec_bit + SH_W'(CS_IDX_W) <= win_log2)
      region = shifted[CS_IDX_W-1:0];
    else if (dec_bit + SH_W'(1) == win_log2)
      region = CS_IDX_W'(shifted[0]);
    else
      region = '0;
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_no[g] = !(hit && (region == CS_IDX_W'(g)));
  end
endmodule

// File: rtl/lbcs_mem_dec.sv
module lbcs_mem_dec #(
  parameter int ADDR_W   = 32,
  parameter int NUM_CS   = 4,
  parameter int WIN_LOG2 = 12
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [NUM_CS-1:0] cs_no
);
  localparam int CS_IDX_W = $clog2(NUM_CS);

  logic                hit;
  logic [CS_IDX_W-1:0] region;

  assign hit    = valid_i && (addr_i[ADDR_W-1:WIN_LOG2] == base_i[ADDR_W-1:WIN_LOG2]);
  assign region = addr_i[WIN_LOG2-1 -: CS_IDX_W];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_no[g] = !(hit && (region == CS_IDX_W'(g)));
  end
endmodule

// File: rtl/lbcs_rst_clk.sv
module lbcs_rst_clk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic clk_en_i,
  output logic lrst_o,
  output logic lrst_no,
  output logic lclk_o
);
  assign lrst_o  = !rst_ni || soft_rst_i;
  assign lrst_no = !lrst_o;
  assign lclk_o  = clk_i & clk_en_i;
endmodule

// File: rtl/lbus_cs_decoder.sv
module lbus_cs_decoder
  import lbcs_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int NUM_CS        = 4,
  parameter int MEM_WIN_LOG2  = 12,
  parameter int MIN_WIN_LOG2  = 2,
  parameter int MAX_SIZE_CODE = 6,
  parameter int SPLIT_BASE    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_valid_i,
  input  logic              cyc_is_mem_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] io_base_i,
  input  logic [ADDR_W-1:0] mem_base_i,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [NUM_CS-1:0] io_cs_no,
  output logic [NUM_CS-1:0] mem_cs_no,
  output logic              lrst_o,
  output logic              lrst_no,
  output logic              lclk_o
);
  cfg_t cfg;

  lbcs_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  lbcs_io_dec #(
    .ADDR_W        (ADDR_W),
    .NUM_CS        (NUM_CS),
    .MIN_WIN_LOG2  (MIN_WIN_LOG2),
    .MAX_SIZE_CODE (MAX_SIZE_CODE),
    .SPLIT_BASE    (SPLIT_BASE)
  ) u_io (
    .valid_i     (cyc_valid_i && !cyc_is_mem_i),
    .addr_i      (addr_i),
    .base_i      (io_base_i),
    .size_code_i (cfg.io_size),
    .split_sel_i (cfg.split_sel),
    .cs_no       (io_cs_no)
  );

  lbcs_mem_dec #(
    .ADDR_W   (ADDR_W),
    .NUM_CS   (NUM_CS),
    .WIN_LOG2 (MEM_WIN_LOG2)
  ) u_mem (
    .valid_i (cyc_valid_i && cyc_is_mem_i),
    .addr_i  (addr_i),
    .base_i  (mem_base_i),
    .cs_no   (mem_cs_no)
  );

  lbcs_rst_clk u_rc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (cfg.soft_rst),
    .clk_en_i   (cfg.clk_en),
    .lrst_o     (lrst_o),
    .lrst_no    (lrst_no),
    .lclk_o     (lclk_o)
  );
endmodule

// File: rtl/lbcs_checker.sv
module lbcs_checker #(
  parameter int ADDR_W       = 32,
  parameter int NUM_CS       = 4,
  parameter int MEM_WIN_LOG2 = 12,
  parameter int CFG_W        = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cyc_valid_i,
  input logic              cyc_is_mem_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] mem_base_i,
  input logic              cfg_we_i,
  input logic [CFG_W-1:0]  cfg_wdata_i,
  input logic [NUM_CS-1:0] io_cs_no,
  input logic [NUM_CS-1:0] mem_cs_no,
  input logic              lrst_o,
  input logic              lrst_no
);
  localparam int CS_IDX_W = $clog2(NUM_CS);

  logic                mem_hit;
  logic [CS_IDX_W-1:0] mem_idx;
  assign mem_hit = cyc_valid_i && cyc_is_mem_i &&
                   (addr_i[ADDR_W-1:MEM_WIN_LOG2] == mem_base_i[ADDR_W-1:MEM_WIN_LOG2]);
  assign mem_idx = addr_i[MEM_WIN_LOG2-1 -: CS_IDX_W];

  AST_CS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~{io_cs_no, mem_cs_no})); // R7

  AST_IDLE_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_valid_i |-> (&io_cs_no && &mem_cs_no)); // R7

  AST_MEM_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_hit |-> !mem_cs_no[mem_idx]); // R6

  AST_LRST_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lrst_o != lrst_no); // R8

  AST_SOFT_RST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrst_o && !cfg_we_i) |=> lrst_o); // R9

  AST_SOFT_RST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (lrst_o == $past(cfg_wdata_i[7]))); // R10
endmodule

bind lbus_cs_decoder lbcs_checker #(
  .ADDR_W       (ADDR_W),
  .NUM_CS       (NUM_CS),
  .MEM_WIN_LOG2 (MEM_WIN_LOG2),
  .CFG_W        (lbcs_pkg::CFG_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cyc_valid_i  (cyc_valid_i),
  .cyc_is_mem_i (cyc_is_mem_i),
  .addr_i       (addr_i),
  .mem_base_i   (mem_base_i),
  .cfg_we_i     (cfg_we_i),
  .cfg_wdata_i  (cfg_wdata_i),
  .io_cs_no     (io_cs_no),
  .mem_cs_no    (mem_cs_no),
  .lrst_o       (lrst_o),
  .lrst_no      (lrst_no)
);

// File: tb/lbus_cs_decoder_tb_top.sv
`timescale 1ns/1ps
module lbus_cs_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        is_mem = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] io_base = 32'h0000_0300;
  logic [31:0] mem_base = 32'h000A_0000;
  logic        we = 1'b0;
  logic [8:0]  wdata = '0;
  logic [3:0]  io_cs_n, mem_cs_n;
  logic        lrst, lrst_n, lclk;

  int n_vec = 0;
  int n_bad = 0;
  logic [8:0] model_cfg = 9'h00B;

  always #4 clk = ~clk;

  lbus_cs_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cyc_valid_i(valid), .cyc_is_mem_i(is_mem),
    .addr_i(addr), .io_base_i(io_base), .mem_base_i(mem_base),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .io_cs_no(io_cs_n), .mem_cs_no(mem_cs_n),
    .lrst_o(lrst), .lrst_no(lrst_n), .lclk_o(lclk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int win_log2(input logic [8:0] c);
    int s = int'(c[2:0]);
    if (s > 6) s = 6;
    return s + 2;
  endfunction

  function automatic logic [3:0] exp_io(input logic v, input logic m, input logic [31:0] a,
                                         input logic [31:0] b, input logic [8:0] c);
    int w = win_log2(c);
    int d = int'(c[6:3]) + 2;
    int idx;
    if (!v || m) return 4'hF;
    if ((a >> w) != (b >> w)) return 4'hF;
    if (d + 2 <= w) idx = int'((a >> d) & 32'd3);
    else if (d + 1 == w) idx = int'((a >> d) & 32'd1);
    else idx = 0;
    return ~(4'b1 << idx);
  endfunction

  function automatic logic [3:0] exp_mem(input logic v, input logic m, input logic [31:0] a,
                                          input logic [31:0] b);
    if (!v || !m || (a[31:12] != b[31:12])) return 4'hF;
    return ~(4'b1 << a[11:10]);
  endfunction

  task automatic write_cfg(input logic [8:0] v);
    @(negedge clk);
    we = 1'b1; wdata = v;
    @(posedge clk);
    #1 we = 1'b0;
    model_cfg = v;
  endtask

  task automatic cycle(input string req, input logic v, input logic m, input logic [31:0] a);
    @(negedge clk);
    valid = v; is_mem = m; addr = a;
    #1;
    check(req, {28'd0, io_cs_n}, {28'd0, exp_io(v, m, a, io_base, model_cfg)});
    check(req, {28'd0, mem_cs_n}, {28'd0, exp_mem(v, m, a, mem_base)});
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    #3;
    check("R8 reset lrst", {31'd0, lrst}, 32'd1);
    check("R8 reset lrst_n", {31'd0, lrst_n}, 32'd0);
    check("R11 reset lclk", {31'd0, lclk}, 32'd0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1 check("R1 soft reset clear", {31'd0, lrst}, 32'd0);

    // R1 defaults: 32B window, four regions on A4:A3
    cycle("R1 region3", 1'b1, 1'b0, 32'h0000_0318);
    cycle("R1 region1", 1'b1, 1'b0, 32'h0000_0309);
    cycle("R2 outside 32B", 1'b1, 1'b0, 32'h0000_0320);
    @(posedge clk); #1 check("R11 lclk held low", {31'd0, lclk}, 32'd0);

    // R4 split at A4 with 32B window
    write_cfg({2'b00, 4'd2, 3'd3});
    cycle("R4 high half", 1'b1, 1'b0, 32'h0000_0310);
    cycle("R4 low half", 1'b1, 1'b0, 32'h0000_030C);
    // R5 split at A5, above window
    write_cfg({2'b00, 4'd3, 3'd3});
    cycle("R5 single", 1'b1, 1'b0, 32'h0000_031C);
    // R3 split below second-highest (A2 in 256B)
    write_cfg({2'b00, 4'd0, 3'd7});
    cycle("R3 interleave", 1'b1, 1'b0, 32'h0000_03F4);
    cycle("R2 code7 256B", 1'b1, 1'b0, 32'h0000_0380);
    // R4 at 256B: top bit A7
    write_cfg({2'b00, 4'd5, 3'd6});
    cycle("R4 256B top", 1'b1, 1'b0, 32'h0000_0380);
    // R5 at 4B window
    write_cfg({2'b00, 4'd0, 3'd0});
    cycle("R5 4B", 1'b1, 1'b0, 32'h0000_0303);
    cycle("R2 4B outside", 1'b1, 1'b0, 32'h0000_0304);
    // R6/R7 memory and idle
    cycle("R6 mem region2", 1'b1, 1'b1, 32'h000A_0800);
    cycle("R7 mem mismatch", 1'b1, 1'b1, 32'h000B_0800);
    cycle("R7 idle", 1'b0, 1'b0, 32'h0000_0300);

    // R9/R10 soft reset persistence
    write_cfg({2'b01, 4'd1, 3'd3});
    #1 check("R10 soft set", {31'd0, lrst}, 32'd1);
    repeat (4) @(posedge clk);
    #1 check("R9 soft held", {30'd0, lrst, lrst_n}, 32'd2);
    write_cfg({2'b00, 4'd1, 3'd3});
    #1 check("R9 soft cleared", {31'd0, lrst}, 32'd0);
    write_cfg({2'b11, 4'd2, 3'd5});
    @(negedge clk); rst_n = 1'b0;
    #1 check("R8 host reset", {31'd0, lrst}, 32'd1);
    @(negedge clk); rst_n = 1'b1;
    model_cfg = 9'h00B;
    #1 check("R9 defaults back", {31'd0, lrst}, 32'd0);
    cycle("R9 default split", 1'b1, 1'b0, 32'h0000_0318);

    // R11 clock enable
    write_cfg({2'b10, 4'd1, 3'd3});
    @(posedge clk); #1 check("R11 lclk high", {31'd0, lclk}, 32'd1);
    @(negedge clk); #1 check("R11 lclk low", {31'd0, lclk}, 32'd0);
    write_cfg({2'b00, 4'd1, 3'd3});
    @(posedge clk); #1 check("R11 lclk gated", {31'd0, lclk}, 32'd0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r, a;
      logic mm, vv;
      int w;
      if ($urandom_range(0, 15) == 0)
        write_cfg({1'b0, 1'b0, 4'($urandom_range(0, 9)), 3'($urandom)});
      if ($urandom_range(0, 31) == 0) begin
        io_base = $urandom; mem_base = $urandom;
      end
      mm = 1'($urandom);
      vv = ($urandom_range(0, 7) != 0);
      r  = $urandom;
      w  = win_log2(model_cfg);
      if ($urandom_range(0, 3) != 0)
        a = mm ? {mem_base[31:12], r[11:0]}
               : ((io_base >> w) << w) | (r & ((32'd1 << w) - 32'd1));
      else
        a = r;
      cycle("R3 R6 R7 random", vv, mm, a);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule